// File: doc/BRIEF.md
# Two-wire serial memory slave front end

This block sits between a two-wire serial bus and a byte-wide synchronous memory port, and makes a memory array answer as a bus slave. The bus lines arrive as plain inputs and are sampled on a system clock that runs at least eight times faster than the serial clock. The block recognises bus start and stop events and takes in a control byte. It answers only when that byte carries the device-type code and the three strap bits wired to the instance. After that it either loads a two-byte word address and writes data bytes, or streams bytes back to the master. Its only drive on the data line is a pull-low enable, so the line can be shared with other open-drain devices.

Writes move through a 64-byte page: the low six bits of the pointer advance and wrap, and the upper bits hold. Reads walk the full address space. A write-protect input lets the block keep acknowledging its control byte and word address while it refuses data bytes and stores nothing. A repeated start keeps the address pointer, so a master sets an address with a short write header and then reads from it.

Top module: `i2c_ee_slave`

## Requirements
- R1: Until a START (data line falls while the clock line is high) is seen, the block never pulls the data line low and never accesses memory, whatever is clocked on the bus.
- R2: A STOP (data line rises while the clock line is high) releases the data line and returns the block to idle; bytes clocked after it get no acknowledge until the next START.
- R3: The pull-low enable changes only while the clock line is low. An acknowledge is a pull held across the ninth clock pulse of a byte and released after that pulse falls.
- R4: The control byte is received MSB first. Its bits 7..4 must be 1010 and its bits 3..1 must equal the strap pins (bit 3 = strap[2]), or the block gives no acknowledge and ignores the bus until the next START. Bit 0 selects read (1) or write (0).
- R5: After a matching write control byte, the next two bytes form the word address, high byte first. Both are acknowledged, and so is every following data byte, which is written to memory at the pointer.
- R6: After each data byte written, the low 6 pointer bits increment modulo 64 and the upper bits stay fixed.
- R7: While wp_i is high, the control byte and both word-address bytes are still acknowledged and the pointer is still loaded. Data bytes get no acknowledge, memory is not written, and the pointer does not advance.
- R8: In read mode the block sends the byte at the pointer MSB first and advances the full 16-bit pointer by one per byte sent (0xFFFF wraps to 0x0000, with no page wrap). A master acknowledge (data line low on the ninth pulse) continues with the next byte. A master no-acknowledge releases the bus and returns the block to idle.
- R9: A read that starts without a new word address begins at the pointer left by the last transfer: one past the last byte read, or the page-wrapped address after the last byte written.
- R10: A START inside a transaction drops any partly received byte and restarts control-byte reception. A word address that was not completed does not change the pointer.
- R11: mem_rd_o and mem_wr_o are single-cycle pulses that are never high together. Read data is taken from mem_rdata_i one cycle after mem_rd_o. mem_addr_o and mem_wdata_o are valid while mem_wr_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| strap_i | input | 3 | Device select strap pins compared with control byte bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks data-byte writes |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| mem_addr_o | output | ADDR_W | Memory address (the address pointer) |
| mem_wr_o | output | 1 | One-cycle memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_rd_o |

## Verification
The bench writes a run of bytes that starts two short of a page end. A design that carried into the upper bits would scatter the run into the next page, and a later read across that same boundary must then show that reads do not wrap. It holds write protect during a write and then reads the target back. A design that only withheld the acknowledge would still store the byte, and one that silenced the whole header would fail to acknowledge the address. It aborts a word address halfway with a repeated start and follows with a current-address read. That read returns the wrong byte if the partial address leaked into the pointer. It also clocks whole bytes onto an idle bus with no START, where any pull or memory strobe points to a receiver that does not wait for a start condition.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam int BYTE_BITS = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } st_e;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_LOAD,
        PTR_PAGE_INC,
        PTR_FULL_INC
    } ptr_op_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_CODE) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk) begin
            if (rst) pipe_q <= '1;
            else     pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_ee_cond.sv
module i2c_ee_cond
    import i2c_ee_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_p;
        ev_o.scl_fall = ~scl_s & scl_p;
        ev_o.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev_o.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_ee_ptr.sv
module i2c_ee_ptr
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_op_e           op_i,
    input  logic [ADDR_W-1:0] load_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else begin
            unique case (op_i)
                PTR_LOAD:     ptr_q <= load_i;
                PTR_PAGE_INC: ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                PTR_FULL_INC: ptr_q <= ptr_q + ADDR_W'(1);
                default:      ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr_o = ptr_q;

    // R6: a page step never disturbs the page number
    assert_page_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == PTR_PAGE_INC) |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              wp_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    logic [1:0] sync_q;
    bus_ev_t    ev;
    st_e        st_q;
    logic [3:0] cnt_q;
    logic       slot_q;
    logic [7:0] shift_q, tx_q, hi_q;
    logic       pull_q, rd_req_q, rd_pend_q;
    logic       slot_enter, slot_leave;
    ptr_op_e    ptr_op;
    logic [15:0]       word_addr;
    logic [ADDR_W-1:0] ptr;

    i2c_ee_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst(rst), .d_i({scl_i, sda_i}), .q_o(sync_q)
    );

    i2c_ee_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(sync_q[1]), .sda_s(sync_q[0]), .ev_o(ev)
    );

    i2c_ee_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst(rst), .op_i(ptr_op), .load_i(word_addr[ADDR_W-1:0]), .ptr_o(ptr)
    );

    assign slot_enter = ev.scl_fall && (cnt_q == LAST_BIT) && !slot_q;
    assign slot_leave = ev.scl_fall && slot_q;
    assign word_addr  = {hi_q, shift_q};

    always_comb begin
        ptr_op   = PTR_HOLD;
        mem_wr_o = 1'b0;
        if (!ev.start && !ev.stop) begin
            unique case (st_q)
                ST_ALO:  if (slot_enter) ptr_op = PTR_LOAD;
                ST_WDAT: if (slot_enter && !wp_i) begin
                    ptr_op   = PTR_PAGE_INC;
                    mem_wr_o = 1'b1;
                end
                ST_RDAT: if (slot_enter) ptr_op = PTR_FULL_INC;
                default: ptr_op = PTR_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            slot_q    <= 1'b0;
            shift_q   <= '0;
            tx_q      <= '0;
            hi_q      <= '0;
            pull_q    <= 1'b0;
            rd_req_q  <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_req_q  <= 1'b0;
            rd_pend_q <= rd_req_q;
            if (rd_pend_q) tx_q <= mem_rdata_i;

            if (ev.stop) begin
                st_q   <= ST_IDLE;
                cnt_q  <= '0;
                slot_q <= 1'b0;
                pull_q <= 1'b0;
            end else if (ev.start) begin
                st_q   <= ST_CTRL;
                cnt_q  <= '0;
                slot_q <= 1'b0;
                pull_q <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (ev.scl_rise && !slot_q && cnt_q < LAST_BIT) begin
                            shift_q <= {shift_q[6:0], ev.sda};
                            cnt_q   <= cnt_q + 4'd1;
                        end
                        if (slot_enter) begin
                            slot_q <= 1'b1;
                            unique case (st_q)
                                ST_CTRL: begin
                                    if (ctrl_hit(shift_q, strap_i)) begin
                                        pull_q   <= 1'b1;
                                        rd_req_q <= shift_q[0];
                                    end else begin
                                        st_q   <= ST_IDLE;
                                        slot_q <= 1'b0;
                                        cnt_q  <= '0;
                                    end
                                end
                                ST_AHI: begin
                                    hi_q   <= shift_q;
                                    pull_q <= 1'b1;
                                end
                                ST_WDAT: pull_q <= !wp_i;
                                default: pull_q <= 1'b1;
                            endcase
                        end
                        if (slot_leave) begin
                            slot_q <= 1'b0;
                            cnt_q  <= '0;
                            pull_q <= 1'b0;
                            unique case (st_q)
                                ST_CTRL: if (shift_q[0]) begin
                                    st_q   <= ST_RDAT;
                                    pull_q <= ~tx_q[7];
                                end else begin
                                    st_q <= ST_AHI;
                                end
                                ST_AHI:  st_q <= ST_ALO;
                                ST_ALO:  st_q <= ST_WDAT;
                                default: st_q <= st_q;
                            endcase
                        end
                    end
                    ST_RDAT: begin
                        if (ev.scl_rise) begin
                            if (slot_q) begin
                                if (ev.sda) begin
                                    st_q   <= ST_IDLE;
                                    slot_q <= 1'b0;
                                    cnt_q  <= '0;
                                end
                            end else if (cnt_q < LAST_BIT) begin
                                cnt_q <= cnt_q + 4'd1;
                            end
                        end
                        if (ev.scl_fall) begin
                            if (slot_q) begin
                                slot_q <= 1'b0;
                                cnt_q  <= '0;
                                pull_q <= ~tx_q[7];
                            end else if (cnt_q == LAST_BIT) begin
                                slot_q   <= 1'b1;
                                pull_q   <= 1'b0;
                                rd_req_q <= 1'b1;
                            end else begin
                                pull_q <= ~tx_q[3'd7 - cnt_q[2:0]];
                            end
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_pull_o  = pull_q;
    assign mem_addr_o  = ptr;
    assign mem_wdata_o = shift_q;
    assign mem_rd_o    = rd_req_q;

    // R3: the drive on the data line only moves while the clock line is low
    assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !ev.scl);
    // R2: a stop puts the block in idle with the line released
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st_q == ST_IDLE) && !sda_pull_o);
    // R1: an idle block never drives the line
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !sda_pull_o);
    // R10: any start restarts control-byte reception from bit zero
    assert_start_ctrl_R10: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st_q == ST_CTRL) && (cnt_q == 4'd0));
    // R11: memory strobes are exclusive and a read strobe lasts one cycle
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_o && mem_rd_o));
    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> !mem_rd_o);
endmodule

// File: tb/i2c_ee_slave_tb_top.sv
module i2c_ee_slave_tb_top;
    localparam int Q = 5;
    localparam int H = 10;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp_m = 1'b0;
    logic sda_line;
    logic sda_pull_o, mem_wr_o, mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_q = 8'h00;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int wr_cnt = 0, rd_cnt = 0, pull_cnt = 0, r3_bad = 0, r11_bad = 0;
    logic pull_prev = 1'b0;
    logic rd_prev = 1'b0;

    logic [7:0] dev_mem [int];
    logic [7:0] exp_mem [int];
    int exp_ptr = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_o;

    i2c_ee_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
        .wp_i(wp_m), .sda_pull_o(sda_pull_o), .mem_addr_o(mem_addr_o),
        .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rd_o(mem_rd_o),
        .mem_rdata_i(mem_rdata_q)
    );

    always @(posedge clk) begin
        if (mem_wr_o) dev_mem[int'(mem_addr_o)] = mem_wdata_o;
        if (mem_rd_o)
            mem_rdata_q <= dev_mem.exists(int'(mem_addr_o)) ? dev_mem[int'(mem_addr_o)] : 8'h00;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_wr_o) wr_cnt++;
            if (mem_rd_o) rd_cnt++;
            if (sda_pull_o) pull_cnt++;
            if (sda_pull_o != pull_prev && scl_m) r3_bad++;
            if ((mem_wr_o && mem_rd_o) || (mem_rd_o && rd_prev)) r11_bad++;
        end
        pull_prev = sda_pull_o;
        rd_prev = mem_rd_o;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_get(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    function automatic int page_next(input int a);
        return (a & 32'hFFC0) | ((a + 1) & 32'h3F);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(H / 2);
        b = sda_line; wait_clk(H / 2);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic set_addr(input int a, input string tag);
        logic ak;
        bus_start();
        put_byte({4'b1010, STRAP, 1'b0}, ak); chk({tag, " ctrl ack"}, ak, 1);
        put_byte(a[15:8], ak);                chk({tag, " addr hi ack"}, ak, 1);
        put_byte(a[7:0], ak);                 chk({tag, " addr lo ack"}, ak, 1);
        exp_ptr = a & 32'hFFFF;
    endtask

    task automatic bus_write(input int a, input int n, input logic [7:0] d [8], input logic wp);
        logic ak;
        wp_m = wp;
        set_addr(a, "R5");
        for (int i = 0; i < n; i++) begin
            put_byte(d[i], ak);
            if (wp) chk("R7 data nack under protect", ak, 0);
            else begin
                chk("R5 data ack", ak, 1);
                exp_mem[exp_ptr] = d[i];
                exp_ptr = page_next(exp_ptr);
            end
        end
        bus_stop();
        wp_m = 1'b0;
    endtask

    task automatic read_body(input int n, input string tag);
        logic ak;
        logic [7:0] v;
        put_byte({4'b1010, STRAP, 1'b1}, ak); chk({tag, " read ctrl ack"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v);
            chk({tag, " read data"}, v, exp_get(exp_ptr));
            exp_ptr = (exp_ptr + 1) & 32'hFFFF;
        end
        bus_stop();
    endtask

    task automatic read_random(input int a, input int n, input string tag);
        set_addr(a, "R10");
        bus_start();
        read_body(n, tag);
    endtask

    task automatic read_current(input int n, input string tag);
        bus_start();
        read_body(n, tag);
    endtask

    initial begin : main
        logic [7:0] d [8];
        logic ak;
        int w0, r0, p0, a;
        int n;
        logic wp;
        void'($urandom(32'h5eed_1234));
        wait_clk(6);
        rst = 1'b0;
        wait_clk(2);
        chk("R1 reset pull", sda_pull_o, 0);
        chk("R11 reset wr", mem_wr_o, 0);
        chk("R11 reset rd", mem_rd_o, 0);

        // R1/R2: bytes on an idle bus with no start
        scl_m = 1'b0; wait_clk(Q);
        w0 = wr_cnt; r0 = rd_cnt; p0 = pull_cnt;
        put_byte({4'b1010, STRAP, 1'b0}, ak); chk("R1 no ack without start", ak, 0);
        put_byte(8'h00, ak);                  chk("R1 no ack without start 2", ak, 0);
        chk("R1 no pull without start", pull_cnt - p0, 0);
        chk("R1 no memory access", (wr_cnt - w0) + (rd_cnt - r0), 0);

        // R4: wrong type code, then wrong strap
        bus_start();
        put_byte({4'b1011, STRAP, 1'b0}, ak); chk("R4 bad type nack", ak, 0);
        put_byte(8'h12, ak);                  chk("R4 ignored after mismatch", ak, 0);
        bus_stop();
        bus_start();
        put_byte({4'b1010, 3'b001, 1'b0}, ak); chk("R4 bad strap nack", ak, 0);
        bus_stop();

        // R2: a stop mid-header, then bytes clocked after it
        set_addr(16'h0420, "R2");
        bus_stop();
        scl_m = 1'b0; wait_clk(Q);
        p0 = pull_cnt;
        put_byte(8'h5A, ak); chk("R2 no ack after stop", ak, 0);
        chk("R2 no pull after stop", pull_cnt - p0, 0);

        // R5/R6: run crossing the page end wraps inside the page
        d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3; d[3] = 8'hD4;
        bus_write(16'h0A3E, 4, d, 1'b0);
        chk("R6 pointer after wrap", exp_ptr, 16'h0A02);
        read_random(16'h0A00, 2, "R6");
        // R8: reads cross the page boundary without wrapping
        read_random(16'h0A3E, 4, "R8");
        // R9: current-address read continues after last read
        read_current(1, "R9");
        chk("R9 pointer after reads", exp_ptr, 16'h0A43);
        // R9: current-address read after a write
        d[0] = 8'h11; d[1] = 8'h22;
        bus_write(16'h0100, 1, d, 1'b0);
        d[0] = 8'h66;
        bus_write(16'h0101, 1, d, 1'b0);
        bus_write(16'h0100, 0, d, 1'b0);
        bus_write(16'h0100, 0, d, 1'b0);
        read_random(16'h0100, 1, "R9");
        read_current(1, "R9");

        // R7: write protect
        w0 = wr_cnt;
        d[0] = 8'h77;
        bus_write(16'h0300, 1, d, 1'b1);
        chk("R7 no write strobe", wr_cnt - w0, 0);
        read_current(1, "R7");
        read_random(16'h0300, 1, "R7");

        // R8: full 16-bit wrap on reads
        d[0] = 8'hEE;
        bus_write(16'hFFFF, 1, d, 1'b0);
        d[0] = 8'h0F;
        bus_write(16'h0000, 1, d, 1'b0);
        read_random(16'hFFFF, 2, "R8");

        // R10: repeated start inside the word address keeps the pointer
        set_addr(16'h0A3E, "R10");
        bus_start();
        read_body(1, "R10");
        bus_start();
        put_byte({4'b1010, STRAP, 1'b0}, ak); chk("R10 ctrl ack", ak, 1);
        put_byte(8'h7C, ak);                  chk("R10 addr hi ack", ak, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        read_body(1, "R10");

        // random traffic checked against the bench model
        for (int it = 0; it < 10; it++) begin
            a = int'($urandom & 32'hFFFF);
            n = 1 + int'($urandom % 6);
            wp = (($urandom % 4) == 0);
            for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
            bus_write(a, n, d, wp);
            read_random(a, n, "R5");
        end

        chk("R3 pull changed with clock high", r3_bad, 0);
        chk("R11 strobe overlap or width", r11_bad, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule